// File: doc/BRIEF.md
# Mirror Probe Allocation Engine

This block owns a small table of mirror probes and services requests to add or remove mirror sessions on it. Each probe holds three things:
- a 64-bit mask of the source ports it copies traffic from;
- a direction code;
- the one monitor port that receives the copies.

The frame datapath reads the table contents straight from the block's outputs. The datapath itself is outside this block.

An add request carries a source port, a monitor port and a direction. The engine runs three ordered scans over the probes, looking at one probe per cycle:
1. It rejects a source port that already serves as a monitor.
2. It reuses a probe that already has the same direction and monitor port.
3. Failing that, it claims the lowest empty probe.

It then commits the change, or it answers with an error code. A remove request names a source port and a probe index. It clears the port's bit and tears the probe down when no source is left.

Requests use a valid/busy handshake. A request is taken only while `busy` is low. Each request produces exactly one single-cycle response that carries a 2-bit status and a 2-bit probe index.

Top module: `mpa_engine`

## Requirements
- R1: An add whose source port equals its monitor port answers status 1 (invalid), probe 0, and leaves the table unchanged.
- R2: An add whose source port is the monitor port of any probe answers status 1, probe 0, and leaves the table unchanged.
- R3: An add reuses the lowest-index probe whose direction code and monitor port both equal the request's.
- R4: If no probe qualifies for reuse, an add claims the lowest-index probe whose source mask is all zeros, including a probe freed by an earlier remove.
- R5: If neither scan finds a probe, the add answers status 2 (no resource), probe 0, and leaves the table unchanged.
- R6: If the chosen probe already holds the source port, the add answers status 3 (exists) with that probe's index and leaves the table unchanged.
- R7: A successful add answers status 0 with the chosen probe's index. It sets source bit `src` of that probe's mask, writes direction code 1 for egress or 2 for ingress, and writes the monitor port.
- R8: A remove answers status 0 with the given probe index and clears bit `src` of that probe. If the mask becomes empty, the direction becomes 0 and the monitor becomes 65. A probe index of 3 answers status 1, probe 0, with no change.
- R9: After reset every mask is zero, every direction is 0, every monitor is 65, and `busy` and `rsp_valid` are low.
- R10: `busy` is high from the acceptance edge through the response cycle. `rsp_valid` is a single-cycle pulse. Requests presented while busy are ignored.
- R11: With one probe examined per cycle, counted in clock edges after the accepting edge, the response appears as follows:
  - a source equal to its monitor: 0 edges;
  - a monitor conflict at probe k: 1+k edges;
  - reuse of probe k: 5+k edges;
  - claim of empty probe k: 8+k edges;
  - no resource: 9 edges;
  - any remove: 1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_del | input | 1 | 0 = add session, 1 = remove session |
| req_src | input | 6 | Source port number |
| req_mon | input | 7 | Monitor port number (add only) |
| req_ingress | input | 1 | 1 = ingress, 0 = egress (add only) |
| req_probe | input | 2 | Probe index (remove only) |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 no resource, 3 exists |
| rsp_probe | output | 2 | Probe index of the response |
| probe_mask | output | 192 | Source masks, probe p at bits [64p+63:64p] |
| probe_dir | output | 6 | Direction codes, probe p at bits [2p+1:2p] |
| probe_mon | output | 21 | Monitor ports, probe p at bits [7p+6:7p] |

## Verification
The add path is driven with a sequence chosen so that each scan decides in turn. Monitor conflicts are placed at probe 0 and at probe 2, which separates a scan that covers every probe from one that stops early. The reuse cases differ from each other only in direction or only in monitor port, which separates matching on both fields from matching on one. Fills until the table is full, and a remove that empties a probe so that a later add reclaims it, exercise the empty-probe scan and the teardown values. Response latency is measured on every request, and a remove is offered while an add is in flight, which exposes scan-order errors and a leaky handshake.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

  typedef enum logic [1:0] {
    MPA_OK      = 2'd0,
    MPA_INVALID = 2'd1,
    MPA_NORES   = 2'd2,
    MPA_EXISTS  = 2'd3
  } mpa_status_e;

  localparam logic [1:0] MPA_DIR_OFF = 2'd0;
  localparam logic [1:0] MPA_DIR_EGR = 2'd1;
  localparam logic [1:0] MPA_DIR_ING = 2'd2;

  // Direction code that a session of the given sense writes into a probe.
  function automatic logic [1:0] mpa_dir_code(input logic ingress);
    return ingress ? MPA_DIR_ING : MPA_DIR_EGR;
  endfunction

endpackage

// File: rtl/mpa_probe_table.sv
module mpa_probe_table #(
  parameter int NP       = 3,
  parameter int NPORTS   = 64,
  parameter int MON_W    = 7,
  parameter int MON_IDLE = 65,
  localparam int IDX_W   = $clog2(NP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [NPORTS-1:0]       wr_mask,
  input  logic [1:0]              wr_dir,
  input  logic [MON_W-1:0]        wr_mon,
  output logic [NP*NPORTS-1:0]    mask_flat,
  output logic [NP*2-1:0]         dir_flat,
  output logic [NP*MON_W-1:0]     mon_flat
);
  import mpa_pkg::*;

  for (genvar p = 0; p < NP; p++) begin : g_probe
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_flat[p*NPORTS +: NPORTS] <= '0;
        dir_flat[p*2 +: 2]            <= MPA_DIR_OFF;
        mon_flat[p*MON_W +: MON_W]    <= MON_W'(MON_IDLE);
      end else if (hit) begin
        mask_flat[p*NPORTS +: NPORTS] <= wr_mask;
        dir_flat[p*2 +: 2]            <= wr_dir;
        mon_flat[p*MON_W +: MON_W]    <= wr_mon;
      end
    end
  end

endmodule

// File: rtl/mpa_seq.sv
module mpa_seq #(
  parameter int NP       = 3,
  parameter int NPORTS   = 64,
  parameter int MON_W    = 7,
  parameter int MON_IDLE = 65,
  localparam int IDX_W   = $clog2(NP + 1),
  localparam int SRC_W   = $clog2(NPORTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_del,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [MON_W-1:0]        req_mon,
  input  logic                    req_ingress,
  input  logic [IDX_W-1:0]        req_probe,
  input  logic [NP*NPORTS-1:0]    tbl_mask,
  input  logic [NP*2-1:0]         tbl_dir,
  input  logic [NP*MON_W-1:0]     tbl_mon,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [NPORTS-1:0]       wr_mask,
  output logic [1:0]              wr_dir,
  output logic [MON_W-1:0]        wr_mon,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic [IDX_W-1:0]        rsp_probe
);
  import mpa_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NP - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CONF, S_REUSE, S_FREE, S_COMMIT, S_DEL, S_RESP
  } state_e;

  state_e          state_q;
  logic [IDX_W-1:0] idx_q, sel_q;
  logic [SRC_W-1:0] src_q;
  logic [MON_W-1:0] mon_q;
  logic [1:0]       dir_q;
  mpa_status_e      status_q;

  function automatic logic [NPORTS-1:0] port_bit(input logic [SRC_W-1:0] p);
    return NPORTS'(1) << p;
  endfunction

  // Probe under scan and probe selected for commit/remove.
  logic [IDX_W-1:0]  sel_safe;
  logic [NPORTS-1:0] cur_mask, sel_mask, del_mask;
  logic [1:0]        cur_dir, sel_dir;
  logic [MON_W-1:0]  cur_mon, sel_mon, src_ext;
  logic              last, sel_ok, sel_has_src, conf_hit, reuse_hit, free_hit;

  assign sel_ok   = (sel_q <= LAST_IDX);
  assign sel_safe = sel_ok ? sel_q : '0;
  assign cur_mask = tbl_mask[int'(idx_q)*NPORTS +: NPORTS];
  assign cur_dir  = tbl_dir[int'(idx_q)*2 +: 2];
  assign cur_mon  = tbl_mon[int'(idx_q)*MON_W +: MON_W];
  assign sel_mask = tbl_mask[int'(sel_safe)*NPORTS +: NPORTS];
  assign sel_dir  = tbl_dir[int'(sel_safe)*2 +: 2];
  assign sel_mon  = tbl_mon[int'(sel_safe)*MON_W +: MON_W];
  assign src_ext  = MON_W'(src_q);
  assign last     = (idx_q == LAST_IDX);

  assign conf_hit    = (cur_mon == src_ext);
  assign reuse_hit   = (cur_dir == dir_q) && (cur_mon == mon_q);
  assign free_hit    = (cur_mask == '0);
  assign sel_has_src = |(sel_mask & port_bit(src_q));
  assign del_mask    = sel_mask & ~port_bit(src_q);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = sel_safe;
    wr_mask = sel_mask;
    wr_dir  = sel_dir;
    wr_mon  = sel_mon;
    if (state_q == S_COMMIT && !sel_has_src) begin
      wr_en   = 1'b1;
      wr_mask = sel_mask | port_bit(src_q);
      wr_dir  = dir_q;
      wr_mon  = mon_q;
    end else if (state_q == S_DEL && sel_ok) begin
      wr_en   = 1'b1;
      wr_mask = del_mask;
      if (del_mask == '0) begin
        wr_dir = MPA_DIR_OFF;
        wr_mon = MON_W'(MON_IDLE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      sel_q    <= '0;
      src_q    <= '0;
      mon_q    <= '0;
      dir_q    <= MPA_DIR_OFF;
      status_q <= MPA_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          src_q    <= req_src;
          mon_q    <= req_mon;
          dir_q    <= mpa_dir_code(req_ingress);
          idx_q    <= '0;
          sel_q    <= req_del ? req_probe : '0;
          status_q <= MPA_OK;
          if (req_del)                            state_q <= S_DEL;
          else if (MON_W'(req_src) == req_mon) begin
            status_q <= MPA_INVALID;
            state_q  <= S_RESP;
          end else                                state_q <= S_CONF;
        end
        S_CONF:
          if (conf_hit) begin
            status_q <= MPA_INVALID;
            state_q  <= S_RESP;
          end else if (last) begin
            idx_q   <= '0;
            state_q <= S_REUSE;
          end else idx_q <= idx_q + 1'b1;
        S_REUSE:
          if (reuse_hit) begin
            sel_q   <= idx_q;
            state_q <= S_COMMIT;
          end else if (last) begin
            idx_q   <= '0;
            state_q <= S_FREE;
          end else idx_q <= idx_q + 1'b1;
        S_FREE:
          if (free_hit) begin
            sel_q   <= idx_q;
            state_q <= S_COMMIT;
          end else if (last) begin
            status_q <= MPA_NORES;
            state_q  <= S_RESP;
          end else idx_q <= idx_q + 1'b1;
        S_COMMIT: begin
          if (sel_has_src) status_q <= MPA_EXISTS;
          state_q <= S_RESP;
        end
        S_DEL: begin
          if (!sel_ok) begin
            status_q <= MPA_INVALID;
            sel_q    <= '0;
          end
          state_q <= S_RESP;
        end
        S_RESP:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = status_q;
  assign rsp_probe  = sel_q;

endmodule

// File: rtl/mpa_engine.sv
module mpa_engine #(
  parameter int NP       = 3,
  parameter int NPORTS   = 64,
  parameter int MON_W    = 7,
  parameter int MON_IDLE = 65,
  localparam int IDX_W   = $clog2(NP + 1),
  localparam int SRC_W   = $clog2(NPORTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_del,
  input  logic [SRC_W-1:0]      req_src,
  input  logic [MON_W-1:0]      req_mon,
  input  logic                  req_ingress,
  input  logic [IDX_W-1:0]      req_probe,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_status,
  output logic [IDX_W-1:0]      rsp_probe,
  output logic [NP*NPORTS-1:0]  probe_mask,
  output logic [NP*2-1:0]       probe_dir,
  output logic [NP*MON_W-1:0]   probe_mon
);

  logic               tbl_wr;
  logic [IDX_W-1:0]   tbl_wr_idx;
  logic [NPORTS-1:0]  tbl_wr_mask;
  logic [1:0]         tbl_wr_dir;
  logic [MON_W-1:0]   tbl_wr_mon;

  mpa_seq #(.NP(NP), .NPORTS(NPORTS), .MON_W(MON_W), .MON_IDLE(MON_IDLE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_del(req_del), .req_src(req_src),
    .req_mon(req_mon), .req_ingress(req_ingress), .req_probe(req_probe),
    .tbl_mask(probe_mask), .tbl_dir(probe_dir), .tbl_mon(probe_mon),
    .wr_en(tbl_wr), .wr_idx(tbl_wr_idx), .wr_mask(tbl_wr_mask),
    .wr_dir(tbl_wr_dir), .wr_mon(tbl_wr_mon),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_probe(rsp_probe)
  );

  mpa_probe_table #(.NP(NP), .NPORTS(NPORTS), .MON_W(MON_W), .MON_IDLE(MON_IDLE)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_idx(tbl_wr_idx), .wr_mask(tbl_wr_mask),
    .wr_dir(tbl_wr_dir), .wr_mon(tbl_wr_mon),
    .mask_flat(probe_mask), .dir_flat(probe_dir), .mon_flat(probe_mon)
  );

endmodule

// File: rtl/mpa_engine_chk.sv
module mpa_engine_chk #(
  parameter int NP       = 3,
  parameter int NPORTS   = 64,
  parameter int MON_W    = 7,
  parameter int MON_IDLE = 65
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  rsp_valid,
  input logic [1:0]            rsp_status,
  input logic [NP*NPORTS-1:0]  probe_mask,
  input logic [NP*2-1:0]       probe_dir,
  input logic [NP*MON_W-1:0]   probe_mon
);

  // R10: a response only appears inside a busy window
  a_r10_rsp_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);

  // R10: response is one cycle long and the engine is free right after
  a_r10_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));

  // R6 (also R1, R2, R5): an error response follows no table change
  a_r6_error_leaves_table: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |->
      ($stable(probe_mask) && $stable(probe_dir) && $stable(probe_mon)));

  // R9: the table only moves while a request is in progress
  a_r9_idle_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(probe_mask) && $stable(probe_dir) && $stable(probe_mon)));

  for (genvar p = 0; p < NP; p++) begin : g_probe_chk
    // R8: an empty probe is torn down
    a_r8_empty_probe_off: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_mask[p*NPORTS +: NPORTS] == '0) |->
        (probe_dir[p*2 +: 2] == 2'd0 && probe_mon[p*MON_W +: MON_W] == MON_W'(MON_IDLE)));
    // R7: a probe holding sources carries a live direction
    a_r7_used_probe_live: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_mask[p*NPORTS +: NPORTS] != '0) |-> (probe_dir[p*2 +: 2] != 2'd0));
  end

endmodule

bind mpa_engine mpa_engine_chk #(.NP(NP), .NPORTS(NPORTS), .MON_W(MON_W), .MON_IDLE(MON_IDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .probe_mask(probe_mask), .probe_dir(probe_dir),
  .probe_mon(probe_mon)
);

// File: tb/tb_mpa_engine.sv
module tb_mpa_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_del = 1'b0, req_ingress = 1'b0;
  logic [5:0] req_src = '0;
  logic [6:0] req_mon = '0;
  logic [1:0] req_probe = '0;
  logic busy, rsp_valid;
  logic [1:0] rsp_status, rsp_probe;
  logic [191:0] probe_mask;
  logic [5:0] probe_dir;
  logic [20:0] probe_mon;

  int total = 0, bad = 0;

  logic [63:0] m_mask [3];
  logic [1:0]  m_dir  [3];
  logic [6:0]  m_mon  [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpa_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_del(req_del),
    .req_src(req_src), .req_mon(req_mon), .req_ingress(req_ingress),
    .req_probe(req_probe), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_probe(rsp_probe), .probe_mask(probe_mask),
    .probe_dir(probe_dir), .probe_mon(probe_mon)
  );

  // del | src(6) | mon(7) | ingress | probe(2) | status(2) | rsp probe(2) | latency(4)
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 6'd1,  7'd10, 1'b0, 2'd0, 2'd0, 2'd0, 4'd8},
    {1'b0, 6'd2,  7'd10, 1'b0, 2'd0, 2'd0, 2'd0, 4'd5},
    {1'b0, 6'd2,  7'd10, 1'b0, 2'd0, 2'd3, 2'd0, 4'd5},
    {1'b0, 6'd3,  7'd10, 1'b1, 2'd0, 2'd0, 2'd1, 4'd9},
    {1'b0, 6'd10, 7'd20, 1'b0, 2'd0, 2'd1, 2'd0, 4'd1},
    {1'b0, 6'd4,  7'd4,  1'b0, 2'd0, 2'd1, 2'd0, 4'd0},
    {1'b0, 6'd5,  7'd30, 1'b1, 2'd0, 2'd0, 2'd2, 4'd10},
    {1'b0, 6'd6,  7'd31, 1'b0, 2'd0, 2'd2, 2'd0, 4'd9},
    {1'b0, 6'd7,  7'd30, 1'b1, 2'd0, 2'd0, 2'd2, 4'd7},
    {1'b1, 6'd1,  7'd0,  1'b0, 2'd0, 2'd0, 2'd0, 4'd1},
    {1'b1, 6'd2,  7'd0,  1'b0, 2'd0, 2'd0, 2'd0, 4'd1},
    {1'b0, 6'd6,  7'd31, 1'b0, 2'd0, 2'd0, 2'd0, 4'd8},
    {1'b0, 6'd31, 7'd40, 1'b0, 2'd0, 2'd1, 2'd0, 4'd1},
    {1'b0, 6'd30, 7'd40, 1'b1, 2'd0, 2'd1, 2'd0, 4'd3},
    {1'b1, 6'd0,  7'd0,  1'b0, 2'd3, 2'd1, 2'd0, 4'd1}
  };
  localparam string TAG [NV] = '{"R4", "R3", "R6", "R7", "R2", "R1", "R4", "R5",
                                 "R3", "R8", "R8", "R4", "R2", "R2", "R8"};

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_table(input string req);
    for (int p = 0; p < 3; p++) begin
      check(probe_mask[p*64 +: 64] == m_mask[p], req, $sformatf("mask[%0d]", p),
            probe_mask[p*64 +: 64], m_mask[p]);
      check(probe_dir[p*2 +: 2] == m_dir[p], req, $sformatf("dir[%0d]", p),
            64'(probe_dir[p*2 +: 2]), 64'(m_dir[p]));
      check(probe_mon[p*7 +: 7] == m_mon[p], req, $sformatf("mon[%0d]", p),
            64'(probe_mon[p*7 +: 7]), 64'(m_mon[p]));
    end
  endtask

  // Drive one request while idle; return response fields and edges to response.
  task automatic run_req(input logic del, input logic [5:0] src, input logic [6:0] mon,
                         input logic ing, input logic [1:0] prb,
                         output logic [1:0] st, output logic [1:0] rp, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_del = del; req_src = src; req_mon = mon;
    req_ingress = ing; req_probe = prb;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    st = rsp_status; rp = rsp_probe;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] st, rp;
    int lat;
    for (int p = 0; p < 3; p++) begin
      m_mask[p] = '0; m_dir[p] = 2'd0; m_mon[p] = 7'd65;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(!busy, "R9", "busy", 64'(busy), 64'd0);
    check(!rsp_valid, "R9", "rsp_valid", 64'(rsp_valid), 64'd0);
    check_table("R9");

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      run_req(v[24], v[23:18], v[17:11], v[10], v[9:8], st, rp, lat);
      check(st == v[7:6], TAG[i], $sformatf("vec%0d status", i), 64'(st), 64'(v[7:6]));
      check(rp == v[5:4], TAG[i], $sformatf("vec%0d probe", i), 64'(rp), 64'(v[5:4]));
      check(lat == int'(v[3:0]), "R11", $sformatf("vec%0d latency", i), 64'(lat), 64'(v[3:0]));
      if (v[7:6] == 2'd0) begin
        if (!v[24]) begin
          m_mask[v[5:4]][v[23:18]] = 1'b1;
          m_dir[v[5:4]] = v[10] ? 2'd2 : 2'd1;
          m_mon[v[5:4]] = v[17:11];
        end else begin
          m_mask[v[5:4]][v[23:18]] = 1'b0;
          if (m_mask[v[5:4]] == '0) begin
            m_dir[v[5:4]] = 2'd0; m_mon[v[5:4]] = 7'd65;
          end
        end
      end
      check_table(TAG[i]);
    end

    // R10: a remove offered during an add in flight is ignored
    @(negedge clk);
    req_valid = 1'b1; req_del = 1'b0; req_src = 6'd8; req_mon = 7'd31;
    req_ingress = 1'b0; req_probe = 2'd0;
    @(posedge clk);
    @(negedge clk);
    check(busy, "R10", "busy after accept", 64'(busy), 64'd1);
    req_del = 1'b1; req_src = 6'd6; req_probe = 2'd0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    req_valid = 1'b0;
    check(rsp_status == 2'd0 && rsp_probe == 2'd0, "R10", "in-flight add response",
          64'({rsp_status, rsp_probe}), 64'd0);
    check(lat == 5, "R11", "in-flight reuse latency", 64'(lat), 64'd5);
    @(negedge clk);
    check(!rsp_valid && !busy, "R10", "pulse ends", 64'({rsp_valid, busy}), 64'd0);
    m_mask[0][8] = 1'b1;
    check_table("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule